// File: doc/BRIEF.md
# Ethernet Core Reset Controller

This block produces the reset signals for a 40G Ethernet MAC/PCS core. It merges active-low hardware reset pins with three software-controlled soft-reset bits held in a small configuration word. It drives four active-high resets: one for the transmit path, one for the receive path, one for the whole core, and one for the register file. Each reset output asserts at once when a hardware pin asserts it and is always released in step with the clock. When a reset bit is set, its output asserts a fixed two clock edges later.

It also produces two readiness flags. `tx_lanes_stable` and `rx_pcs_ready` are held low while their path is in reset. Each one rises a fixed number of cycles after its reset is released, and the wait starts over if the reset comes back during it. Two frame counters, one for transmit and one for receive, are read over the same register bus. These counters are cleared only at power-on or by an explicit clear command, so they keep their counts through a register-block reset.

Software reaches the block through a plain address / write-strobe / read-strobe bus. Read data appears one cycle after the read strobe.

Top module: `eth_rst_ctrl`

## Requirements
- R1: The configuration word is at address 0: bit 0 is soft TX reset, bit 1 is soft RX reset, bit 2 is soft system reset. A write to address 0 loads bits 2..0 from `reg_wdata`. A read strobe at any address updates `reg_rdata` at the next clock edge, using the register state from before that edge, and `reg_rdata` holds that value until the next read. Reading address 0 returns the current bits, zero-extended.
- R2: Soft-reset bits stay set until software writes them to 0. Setting the soft system bit changes no register, including the configuration word.
- R3: `tx_rst_out` asserts at once while `tx_rst_n`, `csr_rst_n` or `por_n` is low. It asserts two clock edges after the soft TX bit or the soft system bit reads 1. It is released two clock edges after all of these sources are inactive.
- R4: `rx_rst_out` follows the same rules as R3, with `rx_rst_n` and the soft RX bit in place of the TX pin and the soft TX bit.
- R5: `sys_rst_out` follows the same timing rules from `csr_rst_n`, `por_n` and the soft system bit. `csr_rst_out` follows only `csr_rst_n` and `por_n` and never reacts to a soft bit.
- R6: `tx_lanes_stable` is low whenever `tx_rst_out` is high. It rises SETTLE clock edges after `tx_rst_out` falls. Any reassertion during the wait restarts the full count.
- R7: `rx_pcs_ready` follows the rules of R6 with respect to `rx_rst_out`.
- R8: While `csr_rst_n` is low, the configuration word and `reg_rdata` are cleared to 0. The frame counters keep their values.
- R9: Address 2 reads the TX frame count and address 3 reads the RX frame count. Each counter adds one per cycle in which its done input is high, and it wraps modulo 2^CNT_W. Writing address 1 with bit 0 set clears both counters, and the clear wins over a same-cycle increment. `por_n` low clears both counters. Address 1 and every unmapped address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and register clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| csr_rst_n | input | 1 | Register-block hard reset, active low |
| tx_rst_n | input | 1 | Transmit-path hard reset, active low |
| rx_rst_n | input | 1 | Receive-path hard reset, active low |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data, one cycle after the strobe |
| tx_frame_done | input | 1 | One-cycle pulse per transmitted frame |
| rx_frame_done | input | 1 | One-cycle pulse per received frame |
| tx_rst_out | output | 1 | Transmit PCS and MAC reset, active high |
| rx_rst_out | output | 1 | Receive PCS and MAC reset, active high |
| sys_rst_out | output | 1 | Whole-core reset, active high |
| csr_rst_out | output | 1 | Register-file reset, active high |
| tx_lanes_stable | output | 1 | Transmit lanes settled |
| rx_pcs_ready | output | 1 | Receive PCS ready |

## Verification
The hardest situation to reach from the ports is a reset that comes back while a readiness flag is still counting toward release. The bench pulses `tx_rst_n` low for a single cycle part-way through the settle wait. It then confirms that the flag stays low past the point where the first count would have ended. A second hard-to-reach case is a `csr_rst_n` pulse that arrives after the frame counters hold nonzero counts and soft bits are set. The bench builds up both counts first, then fires the reset and reads everything back. A clear command issued in the same cycle as a frame pulse, and a counter wrap at the bench's reduced counter width, round out the corners.

// File: rtl/eth_rstc_pkg.sv
package eth_rstc_pkg;
  // register addresses
  localparam int unsigned ADR_CFG      = 0;
  localparam int unsigned ADR_CNT_CTRL = 1;
  localparam int unsigned ADR_TX_CNT   = 2;
  localparam int unsigned ADR_RX_CNT   = 3;
  // configuration word bit positions
  localparam int unsigned BIT_SOFT_TX  = 0;
  localparam int unsigned BIT_SOFT_RX  = 1;
  localparam int unsigned BIT_SOFT_SYS = 2;
  localparam int unsigned CFG_W        = 3;
  // counter control bit
  localparam int unsigned BIT_CNT_CLR  = 0;
  // reset domains
  localparam int unsigned DOM_TX  = 0;
  localparam int unsigned DOM_RX  = 1;
  localparam int unsigned DOM_SYS = 2;
  localparam int unsigned DOM_CSR = 3;
  localparam int unsigned NUM_DOM = 4;
endpackage

// File: rtl/eth_rstc_sync.sv
module eth_rstc_sync (
  input  logic clk,
  input  logic arst,
  input  logic srst,
  output logic rst_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) stage_q <= 2'b11;
    else      stage_q <= {stage_q[0], srst};
  end

  assign rst_out = stage_q[1];
endmodule

// File: rtl/eth_rstc_settle.sv
module eth_rstc_settle #(
  parameter int unsigned SETTLE = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic rst_in,
  output logic ready
);
  localparam int unsigned CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          reach;

  assign reach = (cnt_q == LAST);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (rst_in) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (reach) done_q <= 1'b1;
      else       cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign ready = done_q & ~rst_in;
endmodule

// File: rtl/eth_rstc_regs.sv
module eth_rstc_regs
  import eth_rstc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              csr_rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_frame_done,
  input  logic              rx_frame_done,
  output logic [CFG_W-1:0]  soft_bits,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count
);
  logic csr_arst;
  logic por_arst;
  logic cfg_wr;
  logic cnt_clr;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] rdata_q;
  logic [1:0]        frame_in;
  logic [CNT_W-1:0]  cnt_q [2];

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                input logic inc, input logic clr);
    if (clr) return '0;
    return cur + CNT_W'(inc);
  endfunction

  function automatic logic [DATA_W-1:0] rd_mux(input logic [ADDR_W-1:0] a,
                                               input logic [CFG_W-1:0] cfg,
                                               input logic [CNT_W-1:0] txc,
                                               input logic [CNT_W-1:0] rxc);
    logic [DATA_W-1:0] v;
    v = '0;
    if (a == ADDR_W'(ADR_CFG))         v = DATA_W'(cfg);
    else if (a == ADDR_W'(ADR_TX_CNT)) v = DATA_W'(txc);
    else if (a == ADDR_W'(ADR_RX_CNT)) v = DATA_W'(rxc);
    return v;
  endfunction

  assign csr_arst = ~por_n | ~csr_rst_n;
  assign por_arst = ~por_n;
  assign cfg_wr   = reg_wr && (reg_addr == ADDR_W'(ADR_CFG));
  assign cnt_clr  = reg_wr && (reg_addr == ADDR_W'(ADR_CNT_CTRL)) && reg_wdata[BIT_CNT_CLR];
  assign frame_in = {rx_frame_done, tx_frame_done};

  always_ff @(posedge clk or posedge csr_arst) begin
    if (csr_arst)    cfg_q <= '0;
    else if (cfg_wr) cfg_q <= reg_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or posedge csr_arst) begin
    if (csr_arst)    rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux(reg_addr, cfg_q, cnt_q[0], cnt_q[1]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk or posedge por_arst) begin
      if (por_arst) cnt_q[g] <= '0;
      else          cnt_q[g] <= cnt_next(cnt_q[g], frame_in[g], cnt_clr);
    end
  end

  assign soft_bits = cfg_q;
  assign reg_rdata = rdata_q;
  assign tx_count  = cnt_q[0];
  assign rx_count  = cnt_q[1];
endmodule

// File: rtl/eth_rst_ctrl.sv
module eth_rst_ctrl
  import eth_rstc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SETTLE = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              csr_rst_n,
  input  logic              tx_rst_n,
  input  logic              rx_rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_frame_done,
  input  logic              rx_frame_done,
  output logic              tx_rst_out,
  output logic              rx_rst_out,
  output logic              sys_rst_out,
  output logic              csr_rst_out,
  output logic              tx_lanes_stable,
  output logic              rx_pcs_ready
);
  logic [CFG_W-1:0]   cfg_bits;
  logic [CNT_W-1:0]   tx_cnt_q;
  logic [CNT_W-1:0]   rx_cnt_q;
  logic               core_pin;
  logic [NUM_DOM-1:0] dom_arst;
  logic [NUM_DOM-1:0] dom_srst;
  logic [NUM_DOM-1:0] dom_rst;

  eth_rstc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .por_n(por_n), .csr_rst_n(csr_rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_frame_done(tx_frame_done), .rx_frame_done(rx_frame_done),
    .soft_bits(cfg_bits), .tx_count(tx_cnt_q), .rx_count(rx_cnt_q)
  );

  // hardware sources assert asynchronously; soft bits enter the synchronizer
  assign core_pin          = ~csr_rst_n | ~por_n;
  assign dom_arst[DOM_TX]  = core_pin | ~tx_rst_n;
  assign dom_arst[DOM_RX]  = core_pin | ~rx_rst_n;
  assign dom_arst[DOM_SYS] = core_pin;
  assign dom_arst[DOM_CSR] = core_pin;
  assign dom_srst[DOM_TX]  = cfg_bits[BIT_SOFT_TX] | cfg_bits[BIT_SOFT_SYS];
  assign dom_srst[DOM_RX]  = cfg_bits[BIT_SOFT_RX] | cfg_bits[BIT_SOFT_SYS];
  assign dom_srst[DOM_SYS] = cfg_bits[BIT_SOFT_SYS];
  assign dom_srst[DOM_CSR] = 1'b0;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_sync
    eth_rstc_sync u_sync (
      .clk(clk), .arst(dom_arst[d]), .srst(dom_srst[d]), .rst_out(dom_rst[d])
    );
  end

  assign tx_rst_out  = dom_rst[DOM_TX];
  assign rx_rst_out  = dom_rst[DOM_RX];
  assign sys_rst_out = dom_rst[DOM_SYS];
  assign csr_rst_out = dom_rst[DOM_CSR];

  eth_rstc_settle #(.SETTLE(SETTLE)) u_tx_settle (
    .clk(clk), .arst(dom_arst[DOM_TX]), .rst_in(dom_rst[DOM_TX]), .ready(tx_lanes_stable)
  );

  eth_rstc_settle #(.SETTLE(SETTLE)) u_rx_settle (
    .clk(clk), .arst(dom_arst[DOM_RX]), .rst_in(dom_rst[DOM_RX]), .ready(rx_pcs_ready)
  );
endmodule

// File: rtl/eth_rst_ctrl_chk.sv
module eth_rst_ctrl_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              csr_rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              tx_rst_out,
  input logic              rx_rst_out,
  input logic              sys_rst_out,
  input logic              tx_lanes_stable,
  input logic              rx_pcs_ready,
  input logic [2:0]        cfg_bits,
  input logic [CNT_W-1:0]  tx_cnt_q
);
  AST_TX_FLAG_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    tx_rst_out |-> !tx_lanes_stable); // R6

  AST_RX_FLAG_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    rx_rst_out |-> !rx_pcs_ready); // R7

  AST_TX_FLAG_CLEAN_RISE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(tx_lanes_stable) |-> !$past(tx_rst_out)); // R6

  AST_SYS_COVERS_PATHS: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_out |-> (tx_rst_out && rx_rst_out)); // R5

  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!por_n || !csr_rst_n)
    !(reg_wr && reg_addr == ADDR_W'(0)) |=> $stable(cfg_bits)); // R2

  AST_SOFT_TX_REACHES: assert property (@(posedge clk) disable iff (!por_n)
    $past(cfg_bits[0], 2) |-> tx_rst_out); // R3

  AST_TX_CNT_STEP: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (tx_cnt_q == $past(tx_cnt_q) || tx_cnt_q == CNT_W'($past(tx_cnt_q) + 1'b1)
              || tx_cnt_q == '0)); // R8
endmodule

bind eth_rst_ctrl eth_rst_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .csr_rst_n(csr_rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .tx_rst_out(tx_rst_out), .rx_rst_out(rx_rst_out), .sys_rst_out(sys_rst_out),
  .tx_lanes_stable(tx_lanes_stable), .rx_pcs_ready(rx_pcs_ready),
  .cfg_bits(cfg_bits), .tx_cnt_q(tx_cnt_q)
);

// File: tb/eth_rst_ctrl_test.sv
module eth_rst_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int ST = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0, csr_rst_n = 1'b0, tx_rst_n = 1'b0, rx_rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic tx_frame_done = 1'b0, rx_frame_done = 1'b0;
  logic tx_rst_out, rx_rst_out, sys_rst_out, csr_rst_out, tx_lanes_stable, rx_pcs_ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  eth_rst_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .SETTLE(ST)) uut (.*);

  task automatic cmp(input string tag, input string nm, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_q0[4] = '{1, 1, 1, 1};
  int m_q1[4] = '{1, 1, 1, 1};
  int m_cnt[2] = '{0, 0};
  int m_done[2] = '{0, 0};
  int m_cfg = 0;
  int m_tc = 0, m_rc = 0;
  longint m_rdata = 0;

  always @(posedge clk) begin
    int ar[4];
    int sr[4];
    int old_q1[4];
    bit core;
    bit clr;
    core  = !csr_rst_n || !por_n;
    ar[0] = core || !tx_rst_n;
    ar[1] = core || !rx_rst_n;
    ar[2] = core;
    ar[3] = core;
    sr[0] = (m_cfg & 1) != 0 || (m_cfg & 4) != 0;
    sr[1] = (m_cfg & 2) != 0 || (m_cfg & 4) != 0;
    sr[2] = (m_cfg & 4) != 0;
    sr[3] = 0;
    for (int d = 0; d < 4; d++) begin
      old_q1[d] = m_q1[d];
      if (ar[d] != 0) begin m_q1[d] = 1; m_q0[d] = 1; end
      else begin m_q1[d] = m_q0[d]; m_q0[d] = sr[d]; end
    end
    for (int p = 0; p < 2; p++) begin
      if (ar[p] != 0 || old_q1[p] != 0) begin m_cnt[p] = 0; m_done[p] = 0; end
      else if (m_done[p] == 0) begin
        if (m_cnt[p] == ST - 1) m_done[p] = 1; else m_cnt[p]++;
      end
    end
    if (core) m_rdata = 0;
    else if (reg_rd) begin
      case (reg_addr)
        0: m_rdata = m_cfg;
        2: m_rdata = m_tc;
        3: m_rdata = m_rc;
        default: m_rdata = 0;
      endcase
    end
    if (core) m_cfg = 0;
    else if (reg_wr && reg_addr == 0) m_cfg = reg_wdata & 7;
    clr = reg_wr && reg_addr == 1 && reg_wdata[0];
    if (!por_n) begin m_tc = 0; m_rc = 0; end
    else if (clr) begin m_tc = 0; m_rc = 0; end
    else begin
      m_tc = (m_tc + tx_frame_done) % (1 << CW);
      m_rc = (m_rc + rx_frame_done) % (1 << CW);
    end
    #5;
    cmp("R3", "tx_rst_out", tx_rst_out, m_q1[0]);
    cmp("R4", "rx_rst_out", rx_rst_out, m_q1[1]);
    cmp("R5", "sys_rst_out", sys_rst_out, m_q1[2]);
    cmp("R5", "csr_rst_out", csr_rst_out, m_q1[3]);
    cmp("R6", "tx_lanes_stable", tx_lanes_stable, (m_done[0] != 0 && m_q1[0] == 0) ? 1 : 0);
    cmp("R7", "rx_pcs_ready", rx_pcs_ready, (m_done[1] != 0 && m_q1[1] == 0) ? 1 : 0);
    cmp("R1", "reg_rdata", reg_rdata, m_rdata);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output longint v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = AW'(a);
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(input int ntx, input int nrx);
    for (int i = 0; i < ntx || i < nrx; i++) begin
      @(negedge clk); tx_frame_done = (i < ntx); rx_frame_done = (i < nrx);
    end
    @(negedge clk); tx_frame_done = 1'b0; rx_frame_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint v;
    idle(4);
    por_n = 1'b1; csr_rst_n = 1'b1; tx_rst_n = 1'b1; rx_rst_n = 1'b1;
    idle(2);
    cmp("R6", "stable during settle", tx_lanes_stable, 0);
    idle(25);
    cmp("R6", "stable after settle", tx_lanes_stable, 1);
    cmp("R7", "ready after settle", rx_pcs_ready, 1);
    rd(0, v); cmp("R1", "cfg reset value", v, 0);

    // soft TX reset
    wr(0, 1); idle(4);
    cmp("R3", "soft tx asserts", tx_rst_out, 1);
    cmp("R4", "rx untouched by soft tx", rx_rst_out, 0);
    cmp("R6", "stable low in soft tx", tx_lanes_stable, 0);
    rd(0, v); cmp("R1", "cfg readback", v, 1);
    idle(30);
    cmp("R2", "soft tx sticky", tx_rst_out, 1);
    wr(0, 0); idle(22);
    cmp("R6", "stable back", tx_lanes_stable, 1);

    // soft RX reset
    wr(0, 2); idle(4);
    cmp("R4", "soft rx asserts", rx_rst_out, 1);
    cmp("R3", "tx untouched by soft rx", tx_rst_out, 0);
    wr(0, 0); idle(22);
    cmp("R7", "ready back", rx_pcs_ready, 1);

    // soft system reset
    wr(0, 4); idle(4);
    cmp("R5", "soft sys asserts", sys_rst_out, 1);
    cmp("R5", "soft sys leaves csr_rst_out", csr_rst_out, 0);
    cmp("R3", "soft sys drives tx", tx_rst_out, 1);
    rd(0, v); cmp("R2", "soft sys keeps cfg", v, 4);
    wr(0, 0); idle(22);

    // TX pin: async assertion, then restart during settle
    @(negedge clk); tx_rst_n = 1'b0; #1;
    cmp("R3", "tx pin async", tx_rst_out, 1);
    idle(3); tx_rst_n = 1'b1;
    idle(8); tx_rst_n = 1'b0;
    @(negedge clk); tx_rst_n = 1'b1;
    idle(12);
    cmp("R6", "settle restarted", tx_lanes_stable, 0);
    idle(12);
    cmp("R6", "stable after restart", tx_lanes_stable, 1);

    // RX pin
    @(negedge clk); rx_rst_n = 1'b0; #1;
    cmp("R4", "rx pin async", rx_rst_out, 1);
    cmp("R3", "tx untouched by rx pin", tx_rst_out, 0);
    idle(2); rx_rst_n = 1'b1; idle(22);

    // counters and register-block reset
    frames(5, 3);
    rd(2, v); cmp("R9", "tx count", v, 5);
    rd(3, v); cmp("R9", "rx count", v, 3);
    wr(0, 3);
    @(negedge clk); csr_rst_n = 1'b0; #1;
    cmp("R5", "csr pin async", csr_rst_out, 1);
    idle(2); csr_rst_n = 1'b1; idle(3);
    rd(0, v); cmp("R8", "cfg cleared by csr", v, 0);
    rd(2, v); cmp("R8", "tx count kept", v, 5);
    rd(3, v); cmp("R8", "rx count kept", v, 3);
    idle(20);

    // wrap at 2^CW
    frames(254, 0);
    rd(2, v); cmp("R9", "tx count wrap", v, 3);

    // clear, with a same-cycle pulse
    @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = 1; tx_frame_done = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tx_frame_done = 1'b0;
    rd(2, v); cmp("R9", "clear beats pulse", v, 0);
    rd(3, v); cmp("R9", "rx cleared", v, 0);
    frames(2, 0);
    rd(1, v); cmp("R9", "ctrl reads zero", v, 0);
    rd(9, v); cmp("R9", "unmapped reads zero", v, 0);

    // power-on clears counters
    @(negedge clk); por_n = 1'b0; idle(2); por_n = 1'b1; idle(3);
    rd(2, v); cmp("R9", "por clears count", v, 0);
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule